// File: doc/BRIEF.md
# Qualified Data Grant for a Streaming Bus Master

This block sits on the master side of a split address/data bus. It decides when the master may take the data bus. The system arbiter raises a raw data grant, but the grant only counts if three things hold. The master must have a data tenure waiting. The address phase of that tenure must not have been retried while a retry could still apply. The master must also be ready, given how far its own burst has progressed. When all of these hold, the block emits a one-cycle qualified-grant pulse, raises its busy indication and counts the acknowledged beats of the four-beat burst.

Bursts may stream. After the third acknowledge of a burst (the one before the last), the master will accept a grant for its next pending burst. The first beat of that burst then follows the last beat of the current one, with no idle cycle in between. Only one follow-on burst can be queued at a time. With nothing queued, the busy indication drops on the edge that takes the final acknowledge.

Top module: `qual_data_grant`

## Requirements
- R1: A synchronous active-high reset clears the qualified-grant output, the busy flag, the internal streaming flags and the beat counter to zero.
- R2: When the bus is idle, a cycle with raw grant and pending request high, and no retry block, produces a qualified-grant pulse exactly one cycle later. The pulse lasts a single cycle, and busy rises on the same edge.
- R3: No qualified grant is produced in a cycle after one in which either the raw grant or the pending request was low.
- R4: While busy, each acknowledge strobe advances the 2-bit beat counter by one. The counter wraps from 3 to 0, and it reads 0 whenever busy is low.
- R5: When the final acknowledge (counter at 3) arrives and no follow-on burst is queued, busy is low and the counter is 0 from the next edge.
- R6: While busy, a raw grant is ignored until the next-to-last acknowledge (taken with the counter at 2) has been registered. This includes the cycle in which that acknowledge arrives.
- R7: After the next-to-last acknowledge, a grant for a pending request is qualified. At the final acknowledge the counter wraps to 0 and busy stays high, so the new burst's beats follow with no idle cycle.
- R8: Once a follow-on burst is queued, further grants are ignored until that burst has begun.
- R9: An address retry seen in the retry window blocks qualification while the transaction is retriable. The block lasts until the pending request drops.
- R10: An address retry has no effect on qualification when the retriable flag is low.
- R11: A grant that arrives in the same cycle as the final acknowledge, after the next-to-last one, is qualified. The next burst starts back to back, with busy held high and the counter wrapping to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_raw | input | 1 | Data-bus grant from the system arbiter |
| tenure_req | input | 1 | A data tenure is pending for this master |
| retry_win | input | 1 | Marks the address retry window of the pending tenure |
| addr_retry | input | 1 | Address retry, valid during the retry window |
| retriable | input | 1 | The pending transaction can still be retried |
| xfer_ack | input | 1 | Transfer acknowledge, one per data beat |
| qual_grant | output | 1 | One-cycle qualified data-bus grant |
| bus_busy | output | 1 | This master holds the data bus |
| beat_cnt | output | 2 | Beats acknowledged in the current burst |

## Verification
Several cases are probed: a grant arriving early in a burst, on the very cycle of the next-to-last acknowledge, and on the cycle after it. A design that registers that acknowledge a cycle late would insert a dead cycle between bursts. One that qualifies too early would grant in the middle of a burst. The bench also offers a grant on the final acknowledge itself, and a second grant while a follow-on burst is already queued. A faulty design would either drop the bus between bursts or queue two bursts. Retry handling is checked both with the retriable flag set and cleared, and again after the request drops. A wrong design would either grant a retried tenure or stay blocked forever.

// File: rtl/qdg_pkg.sv
package qdg_pkg;
  typedef struct packed {
    logic busy;
    logic penult;
    logic stream;
  } qdg_flags_t;
endpackage

// File: rtl/qdg_retry_filter.sv
module qdg_retry_filter (
  input  logic clk,
  input  logic rst,
  input  logic tenure_req,
  input  logic retry_win,
  input  logic addr_retry,
  input  logic retriable,
  output logic blocked
);
  logic hit_q;
  logic hit_now;

  assign hit_now = retry_win & addr_retry;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else if (!tenure_req) begin
      hit_q <= 1'b0;
    end else if (hit_now) begin
      hit_q <= 1'b1;
    end
  end

  assign blocked = retriable & (hit_q | hit_now);
endmodule

// File: rtl/qdg_beat_counter.sv
module qdg_beat_counter #(
  parameter int BEATS = 4,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [CW-1:0] cnt,
  output logic          at_last,
  output logic          at_penult
);
  localparam logic [CW-1:0] LAST   = CW'(BEATS - 1);
  localparam logic [CW-1:0] PENULT = CW'(BEATS - 2);

  assign at_last   = (cnt == LAST);
  assign at_penult = (cnt == PENULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qdg_tenure_ctl.sv
module qdg_tenure_ctl
  import qdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       qualify,
  input  logic       beat_ack,
  input  logic       at_last,
  input  logic       at_penult,
  output qdg_flags_t flags,
  output logic       ready
);
  logic end_burst;

  assign end_burst = beat_ack & at_last;
  assign ready     = !flags.busy || (flags.penult && !flags.stream);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      if (end_burst) begin
        flags.busy   <= flags.stream | qualify;
        flags.penult <= 1'b0;
        flags.stream <= 1'b0;
      end else begin
        if (qualify) begin
          flags.busy <= 1'b1;
        end
        if (beat_ack && at_penult) begin
          flags.penult <= 1'b1;
        end
        if (qualify && flags.busy) begin
          flags.stream <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qual_data_grant.sv
module qual_data_grant
  import qdg_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant_raw,
  input  logic          tenure_req,
  input  logic          retry_win,
  input  logic          addr_retry,
  input  logic          retriable,
  input  logic          xfer_ack,
  output logic          qual_grant,
  output logic          bus_busy,
  output logic [CW-1:0] beat_cnt
);
  qdg_flags_t flags;
  logic       blocked;
  logic       ready;
  logic       qualify;
  logic       beat_ack;
  logic       at_last;
  logic       at_penult;

  assign beat_ack = xfer_ack & flags.busy;
  assign qualify  = grant_raw & tenure_req & !blocked & ready;

  qdg_retry_filter u_retry (
    .clk        (clk),
    .rst        (rst),
    .tenure_req (tenure_req),
    .retry_win  (retry_win),
    .addr_retry (addr_retry),
    .retriable  (retriable),
    .blocked    (blocked)
  );

  qdg_beat_counter #(.BEATS(BEATS)) u_beats (
    .clk       (clk),
    .rst       (rst),
    .advance   (beat_ack),
    .cnt       (beat_cnt),
    .at_last   (at_last),
    .at_penult (at_penult)
  );

  qdg_tenure_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .qualify   (qualify),
    .beat_ack  (beat_ack),
    .at_last   (at_last),
    .at_penult (at_penult),
    .flags     (flags),
    .ready     (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) qual_grant <= 1'b0;
    else     qual_grant <= qualify;
  end

  assign bus_busy = flags.busy;
endmodule

// File: rtl/qual_data_grant_chk.sv
module qual_data_grant_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          grant_raw,
  input logic          tenure_req,
  input logic          retry_win,
  input logic          addr_retry,
  input logic          retriable,
  input logic          xfer_ack,
  input logic          qual_grant,
  input logic          bus_busy,
  input logic [CW-1:0] beat_cnt
);
  localparam logic [CW-1:0] TOP = '1;

  assert_grant_busy_R2: assert property (@(posedge clk) disable iff (rst)
    qual_grant |-> bus_busy);

  assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    qual_grant |=> !qual_grant);

  assert_no_raw_R3: assert property (@(posedge clk) disable iff (rst)
    (!grant_raw || !tenure_req) |=> !qual_grant);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && xfer_ack && beat_cnt != TOP) |=> (beat_cnt == $past(beat_cnt) + 1'b1));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_busy |-> (beat_cnt == '0));

  assert_early_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && beat_cnt != TOP) |=> !qual_grant);

  assert_retry_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (retriable && retry_win && addr_retry) |=> !qual_grant);
endmodule

bind qual_data_grant qual_data_grant_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .grant_raw  (grant_raw),
  .tenure_req (tenure_req),
  .retry_win  (retry_win),
  .addr_retry (addr_retry),
  .retriable  (retriable),
  .xfer_ack   (xfer_ack),
  .qual_grant (qual_grant),
  .bus_busy   (bus_busy),
  .beat_cnt   (beat_cnt)
);

// File: tb/test_qual_data_grant.sv
module test_qual_data_grant;
  localparam time CLK_PERIOD = 10;
  localparam int  NV = 31;

  logic       clk = 1'b0;
  logic       rst;
  logic       grant_raw, tenure_req, retry_win, addr_retry, retriable, xfer_ack;
  logic       qual_grant, bus_busy;
  logic [1:0] beat_cnt;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qual_data_grant i_qual_data_grant (
    .clk        (clk),
    .rst        (rst),
    .grant_raw  (grant_raw),
    .tenure_req (tenure_req),
    .retry_win  (retry_win),
    .addr_retry (addr_retry),
    .retriable  (retriable),
    .xfer_ack   (xfer_ack),
    .qual_grant (qual_grant),
    .bus_busy   (bus_busy),
    .beat_cnt   (beat_cnt)
  );

  // [9]grant [8]req [7]win [6]retry [5]retriable [4]ack | [3]qg [2]busy [1:0]cnt
  localparam logic [9:0] VEC [NV] = '{
    10'b000000_0000, // 0 idle
    10'b010000_0000, // 1 req without grant
    10'b110000_1100, // 2 idle qualify
    10'b000001_0101, // 3
    10'b000001_0110, // 4
    10'b000001_0111, // 5 next-to-last ack
    10'b000001_0000, // 6 final ack, bus free
    10'b000000_0000, // 7
    10'b110000_1100, // 8 qualify
    10'b110001_0101, // 9 early grant ignored
    10'b010001_0110, // 10
    10'b110001_0111, // 11 grant on penult ack ignored
    10'b110000_1111, // 12 streamed grant
    10'b110001_0100, // 13 final ack, wrap, second grant ignored
    10'b000001_0101, // 14
    10'b000001_0110, // 15
    10'b000001_0111, // 16
    10'b000001_0000, // 17 free
    10'b111110_0000, // 18 retried
    10'b110010_0000, // 19 still blocked
    10'b110000_1100, // 20 not retriable
    10'b000001_0101, // 21 req drops
    10'b000001_0110, // 22
    10'b000001_0111, // 23
    10'b000001_0000, // 24
    10'b110010_1100, // 25 block cleared
    10'b000001_0101, // 26
    10'b000001_0110, // 27
    10'b000001_0111, // 28
    10'b110001_1100, // 29 grant on final ack
    10'b000000_0100  // 30
  };

  localparam string TAG [NV] = '{
    "R3", "R3", "R2", "R4", "R4", "R4", "R5", "R5",
    "R2", "R6", "R4", "R6", "R7", "R8", "R7", "R4",
    "R4", "R5", "R9", "R9", "R10", "R4", "R4", "R4",
    "R5", "R9", "R4", "R4", "R4", "R11", "R11"
  };

  task automatic check(input string req, input int row, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s row %0d: got qg/busy/cnt=%b expected %b", req, row, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {grant_raw, tenure_req, retry_win, addr_retry, retriable, xfer_ack} = v;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(6'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", -1, {qual_grant, bus_busy, beat_cnt}, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:4]);
      @(negedge clk);
      check(TAG[i], i, {qual_grant, bus_busy, beat_cnt}, VEC[i][3:0]);
    end

    // R1: reset while busy mid-burst
    drive(6'b000001);
    @(negedge clk);
    check("R4", 100, {qual_grant, bus_busy, beat_cnt}, 4'b0101);
    rst = 1'b1;
    drive(6'b110000);
    @(negedge clk);
    check("R1", 101, {qual_grant, bus_busy, beat_cnt}, 4'b0000);
    rst = 1'b0;
    // R3: grant without request after reset
    drive(6'b100000);
    @(negedge clk);
    check("R3", 102, {qual_grant, bus_busy, beat_cnt}, 4'b0000);
    // R4: ack while idle has no effect on the counter
    drive(6'b000001);
    @(negedge clk);
    check("R4", 103, {qual_grant, bus_busy, beat_cnt}, 4'b0000);
    // R10: retry in window, not retriable, qualifies at once
    drive(6'b111100);
    @(negedge clk);
    check("R10", 104, {qual_grant, bus_busy, beat_cnt}, 4'b1100);
    drive(6'b000000);
    @(negedge clk);
    check("R2", 105, {qual_grant, bus_busy, beat_cnt}, 4'b0100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule